// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Refill

This block turns a 14-bit virtual address into a 12-bit physical address for a small paged memory system with 64-byte pages. The upper eight bits of the virtual address form the virtual page number. The block splits that number into a set index and a tag. It searches the four ways of the selected set. The page offset goes to the output untouched, next to the stored physical page number. Each lookup produces one registered result, one clock after it is presented. The result is a translated address, a protection fault, or a miss request that carries the page number to a page-table walker.

Refill entries can come from a walker or from software. Each one carries a page number, a physical page number, a writable bit, a supervisor-only bit and a global bit. A refill uses one of three ways, in this order of preference:
- the way that already holds the same tag;
- otherwise the lowest-numbered free way;
- otherwise the way named by a round-robin pointer kept for each set.

A flush, as used on a context switch, invalidates every entry except those marked global.

Top module: `xlat_tlb`

## Requirements
- R1: The virtual address divides into three fields. The page number is bits 13:6, the set index is page-number bits 1:0, the tag is page-number bits 7:2, and the offset is bits 5:0. The physical address is the 6-bit physical page number followed by the unchanged offset.
- R2: When a valid way in the indexed set holds the lookup tag and the access is permitted, the results appear one cycle after the lookup. `res_valid_o` and `res_hit_o` are 1, and `res_pa_o` is {ppn, offset}.
- R3: When no valid way in the indexed set matches, the results appear one cycle later. `res_valid_o` and `miss_req_o` are 1, `miss_vpn_o` carries the page number, and `res_hit_o` is 0 with `res_pa_o` = 0.
- R4: A matching entry produces a fault instead of a hit in two cases: a write to an entry whose writable bit is 0, or a user access (`lkp_user_i`=1) to an entry whose supervisor-only bit is 1. On a fault, `res_fault_o` is 1, `res_hit_o` and `miss_req_o` are 0, and `res_pa_o` is 0. Reads by the supervisor are always allowed.
- R5: A cycle without a lookup gives `res_valid_o` = 0 one cycle later, with every result flag and bus at 0.
- R6: A refill whose tag is already held in its set rewrites that way. Otherwise it fills the lowest-numbered invalid way. When the set is full, it replaces the way named by the set's round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo 4, only on such a replacement.
- R7: A lookup in the same cycle as a refill sees the contents from before the refill. The refilled entry is visible from the next lookup on.
- R8: A flush invalidates every entry whose global bit is 0, in all sets, and keeps global entries. A refill in the same cycle as a flush is applied after the flush, so its entry survives.
- R9: After reset, every entry is invalid and all result outputs are 0.
- R10: At most one way of any set matches a given tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request this cycle |
| lkp_va_i | input | 14 | Virtual address to translate |
| lkp_write_i | input | 1 | Lookup is a write access |
| lkp_user_i | input | 1 | Lookup is made in user mode |
| fill_valid_i | input | 1 | Refill entry this cycle |
| fill_vpn_i | input | 8 | Page number of the refill |
| fill_ppn_i | input | 6 | Physical page number of the refill |
| fill_wr_i | input | 1 | Refilled page is writable |
| fill_sup_i | input | 1 | Refilled page is supervisor-only |
| fill_glb_i | input | 1 | Refilled page is global |
| flush_i | input | 1 | Invalidate all non-global entries |
| res_valid_o | output | 1 | Result of the previous cycle's lookup |
| res_hit_o | output | 1 | Translation delivered |
| res_pa_o | output | 12 | Physical address on a hit, else 0 |
| res_fault_o | output | 1 | Permission denied on a matching entry |
| miss_req_o | output | 1 | Refill request |
| miss_vpn_o | output | 8 | Page number to be refilled, else 0 |

## Verification
Some properties are checked by assertions on every cycle:
- no set ever holds two ways that match a tag;
- a flush without a refill leaves no valid non-global entry;
- a set's round-robin pointer moves only on a refill;
- each valid result raises exactly one of hit, fault or miss;
- a hit carries the lookup offset, and a miss carries the lookup page number.

Other behaviour shows only in the bench scenarios:
- which way a refill replaces, seen through later lookups as the evicted tag missing;
- the one-cycle delay before a refill becomes visible;
- global entries surviving a flush;
- the worked translations of addresses 0x03D4 and 0x0B8F.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned VA_W  = 14;
  localparam int unsigned PA_W  = 12;
  localparam int unsigned OFF_W = 6;
  localparam int unsigned SETS  = 4;
  localparam int unsigned WAYS  = 4;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_HIT   = 2'd1,
    K_MISS  = 2'd2,
    K_FAULT = 2'd3
  } xlat_kind_e;
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm (
  input  logic wr_req_i,
  input  logic usr_req_i,
  input  logic ent_wr_i,
  input  logic ent_sup_i,
  output logic deny_o
);
  always_comb begin
    deny_o = 1'b0;
    if (wr_req_i && !ent_wr_i)   deny_o = 1'b1;
    if (usr_req_i && ent_sup_i)  deny_o = 1'b1;
  end
endmodule

// File: rtl/xlat_set.sv
module xlat_set #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PPN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic             hit_wr_o,
  output logic             hit_sup_o,
  input  logic             fill_en_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_wr_i,
  input  logic             fill_sup_i,
  input  logic             fill_glb_i,
  input  logic             flush_i
);
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]             vld_q, glb_q, wr_q, sup_q;
  logic [WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [WAYS-1:0][PPN_W-1:0]  ppn_q;
  logic [WAY_W-1:0]            rr_q;

  logic [WAYS-1:0]  match, fmatch;
  logic [WAY_W-1:0] vic;
  logic             use_rr;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w]  = vld_q[w] && (tag_q[w] == lk_tag_i);
    assign fmatch[w] = vld_q[w] && (tag_q[w] == fill_tag_i);
  end

  always_comb begin
    hit_o     = |match;
    hit_ppn_o = '0;
    hit_wr_o  = 1'b0;
    hit_sup_o = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_ppn_o = hit_ppn_o | ppn_q[w];
        hit_wr_o  = hit_wr_o  | wr_q[w];
        hit_sup_o = hit_sup_o | sup_q[w];
      end
    end
  end

  // victim: same tag, else lowest free way, else round-robin
  always_comb begin
    vic    = rr_q;
    use_rr = 1'b1;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!vld_q[w]) begin
        vic    = WAY_W'(w);
        use_rr = 1'b0;
      end
    end
    for (int w = WAYS-1; w >= 0; w--) begin
      if (fmatch[w]) begin
        vic    = WAY_W'(w);
        use_rr = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      glb_q <= '0;
      wr_q  <= '0;
      sup_q <= '0;
      tag_q <= '0;
      ppn_q <= '0;
      rr_q  <= '0;
    end else begin
      if (flush_i) vld_q <= vld_q & glb_q;
      if (fill_en_i) begin
        vld_q[vic] <= 1'b1;
        glb_q[vic] <= fill_glb_i;
        wr_q[vic]  <= fill_wr_i;
        sup_q[vic] <= fill_sup_i;
        tag_q[vic] <= fill_tag_i;
        ppn_q[vic] <= fill_ppn_i;
        if (use_rr) rr_q <= rr_q + 1'b1;
      end
    end
  end

  assert_one_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  assert_rr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_en_i |=> $stable(rr_q));

  for (genvar w = 0; w < WAYS; w++) begin : g_chk
    assert_flush_spares_global_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_i && !fill_en_i) |=> !(vld_q[w] && !glb_q[w]));
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int unsigned P_VA_W  = VA_W,
  parameter int unsigned P_PA_W  = PA_W,
  parameter int unsigned P_OFF_W = OFF_W,
  parameter int unsigned P_SETS  = SETS,
  parameter int unsigned P_WAYS  = WAYS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lkp_valid_i,
  input  logic [P_VA_W-1:0]          lkp_va_i,
  input  logic                       lkp_write_i,
  input  logic                       lkp_user_i,
  input  logic                       fill_valid_i,
  input  logic [P_VA_W-P_OFF_W-1:0]  fill_vpn_i,
  input  logic [P_PA_W-P_OFF_W-1:0]  fill_ppn_i,
  input  logic                       fill_wr_i,
  input  logic                       fill_sup_i,
  input  logic                       fill_glb_i,
  input  logic                       flush_i,
  output logic                       res_valid_o,
  output logic                       res_hit_o,
  output logic [P_PA_W-1:0]          res_pa_o,
  output logic                       res_fault_o,
  output logic                       miss_req_o,
  output logic [P_VA_W-P_OFF_W-1:0]  miss_vpn_o
);
  localparam int unsigned VPN_W = P_VA_W - P_OFF_W;
  localparam int unsigned PPN_W = P_PA_W - P_OFF_W;
  localparam int unsigned IDX_W = (P_SETS > 1) ? $clog2(P_SETS) : 1;
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  logic [VPN_W-1:0]   vpn;
  logic [IDX_W-1:0]   idx, fidx;
  logic [TAG_W-1:0]   tag, ftag;
  logic [P_OFF_W-1:0] off;

  assign vpn  = lkp_va_i[P_VA_W-1:P_OFF_W];
  assign off  = lkp_va_i[P_OFF_W-1:0];
  assign idx  = vpn[IDX_W-1:0];
  assign tag  = vpn[VPN_W-1:IDX_W];
  assign fidx = fill_vpn_i[IDX_W-1:0];
  assign ftag = fill_vpn_i[VPN_W-1:IDX_W];

  logic [P_SETS-1:0]            set_hit, set_wr, set_sup;
  logic [P_SETS-1:0][PPN_W-1:0] set_ppn;

  for (genvar s = 0; s < P_SETS; s++) begin : g_set
    xlat_set #(
      .WAYS (P_WAYS),
      .TAG_W(TAG_W),
      .PPN_W(PPN_W)
    ) i_set (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lk_tag_i  (tag),
      .hit_o     (set_hit[s]),
      .hit_ppn_o (set_ppn[s]),
      .hit_wr_o  (set_wr[s]),
      .hit_sup_o (set_sup[s]),
      .fill_en_i (fill_valid_i && (fidx == IDX_W'(s))),
      .fill_tag_i(ftag),
      .fill_ppn_i(fill_ppn_i),
      .fill_wr_i (fill_wr_i),
      .fill_sup_i(fill_sup_i),
      .fill_glb_i(fill_glb_i),
      .flush_i   (flush_i)
    );
  end

  logic deny;
  xlat_perm i_perm (
    .wr_req_i (lkp_write_i),
    .usr_req_i(lkp_user_i),
    .ent_wr_i (set_wr[idx]),
    .ent_sup_i(set_sup[idx]),
    .deny_o   (deny)
  );

  xlat_kind_e kind_d, kind_q;
  logic [P_PA_W-1:0] pa_q;
  logic [VPN_W-1:0]  mvpn_q;

  always_comb begin
    if (!lkp_valid_i)      kind_d = K_NONE;
    else if (!set_hit[idx]) kind_d = K_MISS;
    else if (deny)          kind_d = K_FAULT;
    else                    kind_d = K_HIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_NONE;
      pa_q   <= '0;
      mvpn_q <= '0;
    end else begin
      kind_q <= kind_d;
      pa_q   <= (kind_d == K_HIT)  ? {set_ppn[idx], off} : '0;
      mvpn_q <= (kind_d == K_MISS) ? vpn : '0;
    end
  end

  assign res_valid_o = (kind_q != K_NONE);
  assign res_hit_o   = (kind_q == K_HIT);
  assign res_fault_o = (kind_q == K_FAULT);
  assign miss_req_o  = (kind_q == K_MISS);
  assign res_pa_o    = pa_q;
  assign miss_vpn_o  = mvpn_q;

  assert_one_outcome_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ($countones({res_hit_o, res_fault_o, miss_req_o}) == 1));

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_hit_o && !res_fault_o && !miss_req_o && res_pa_o == '0));

  assert_offset_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> (res_pa_o[P_OFF_W-1:0] == $past(lkp_va_i[P_OFF_W-1:0])));

  assert_miss_vpn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_req_o |-> (miss_vpn_o == $past(lkp_va_i[P_VA_W-1:P_OFF_W])));

  assert_fault_no_pa_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_fault_o |-> (res_pa_o == '0 && miss_vpn_o == '0));
endmodule

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [13:0] lkp_va_i = '0;
  logic        lkp_write_i = 1'b0;
  logic        lkp_user_i = 1'b0;
  logic        fill_valid_i = 1'b0;
  logic [7:0]  fill_vpn_i = '0;
  logic [5:0]  fill_ppn_i = '0;
  logic        fill_wr_i = 1'b0;
  logic        fill_sup_i = 1'b0;
  logic        fill_glb_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        res_valid_o, res_hit_o, res_fault_o, miss_req_o;
  logic [11:0] res_pa_o;
  logic [7:0]  miss_vpn_o;

  always #4 clk_i = ~clk_i;

  xlat_tlb i_xlat_tlb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid_i), .lkp_va_i(lkp_va_i),
    .lkp_write_i(lkp_write_i), .lkp_user_i(lkp_user_i),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_wr_i(fill_wr_i), .fill_sup_i(fill_sup_i), .fill_glb_i(fill_glb_i),
    .flush_i(flush_i),
    .res_valid_o(res_valid_o), .res_hit_o(res_hit_o), .res_pa_o(res_pa_o),
    .res_fault_o(res_fault_o), .miss_req_o(miss_req_o), .miss_vpn_o(miss_vpn_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kinds used by the vector table: 0 hit, 1 miss, 2 fault
  typedef struct packed {
    logic [13:0] va;
    logic        wr;
    logic        usr;
    logic [1:0]  kind;
    logic [11:0] pa;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{va:14'h03D4, wr:1'b0, usr:1'b1, kind:2'd0, pa:12'h354},
    '{va:14'h0B8F, wr:1'b0, usr:1'b1, kind:2'd1, pa:12'h000},
    '{va:14'h0020, wr:1'b0, usr:1'b0, kind:2'd1, pa:12'h000},
    '{va:14'h093F, wr:1'b1, usr:1'b1, kind:2'd0, pa:12'h37F},
    '{va:14'h0AC5, wr:1'b1, usr:1'b1, kind:2'd2, pa:12'h000},
    '{va:14'h0AC5, wr:1'b0, usr:1'b1, kind:2'd0, pa:12'hD05},
    '{va:14'h0361, wr:1'b0, usr:1'b1, kind:2'd2, pa:12'h000},
    '{va:14'h0361, wr:1'b1, usr:1'b0, kind:2'd0, pa:12'hB61},
    '{va:14'h0700, wr:1'b0, usr:1'b0, kind:2'd0, pa:12'h080}
  };

  task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn,
                      input logic wr, input logic sup, input logic glb);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn;
    fill_wr_i = wr; fill_sup_i = sup; fill_glb_i = glb;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic look(input logic [13:0] va, input logic wr, input logic usr);
    @(negedge clk_i);
    lkp_valid_i = 1'b1; lkp_va_i = va; lkp_write_i = wr; lkp_user_i = usr;
    @(negedge clk_i);
    lkp_valid_i = 1'b0;
  endtask

  task automatic exp_hit(input string req, input logic [13:0] va, input logic [11:0] pa);
    look(va, 1'b0, 1'b0);
    chk({req, " hit"}, {res_valid_o, res_hit_o, res_fault_o, miss_req_o}, 4'b1100);
    chk({req, " pa"}, res_pa_o, pa);
  endtask

  task automatic exp_miss(input string req, input logic [13:0] va);
    look(va, 1'b0, 1'b0);
    chk({req, " miss"}, {res_valid_o, res_hit_o, res_fault_o, miss_req_o}, 4'b1001);
    chk({req, " vpn"}, miss_vpn_o, va[13:6]);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    chk("R9 outputs", {res_valid_o, res_hit_o, res_fault_o, miss_req_o, res_pa_o, miss_vpn_o}, '0);
    exp_miss("R9 empty", 14'h03D4);

    // preload: set3 tag03, set0 tag09, set3 tag0A (ro), set1 tag03 (sup), set0 tag07 (ro sup)
    fill(8'h0F, 6'h0D, 1'b1, 1'b0, 1'b0);
    fill(8'h24, 6'h0D, 1'b1, 1'b0, 1'b0);
    fill(8'h2B, 6'h34, 1'b0, 1'b0, 1'b0);
    fill(8'h0D, 6'h2D, 1'b1, 1'b1, 1'b0);
    fill(8'h1C, 6'h02, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < 9; i++) begin
      look(VECS[i].va, VECS[i].wr, VECS[i].usr);
      case (VECS[i].kind)
        2'd0: begin
          chk("R2 hit flags", {res_valid_o, res_hit_o, res_fault_o, miss_req_o}, 4'b1100);
          chk("R1 R2 pa", res_pa_o, VECS[i].pa);
        end
        2'd1: begin
          chk("R3 miss flags", {res_valid_o, res_hit_o, res_fault_o, miss_req_o}, 4'b1001);
          chk("R1 R3 vpn", miss_vpn_o, VECS[i].va[13:6]);
          chk("R3 pa zero", res_pa_o, 12'h000);
        end
        default: begin
          chk("R4 fault flags", {res_valid_o, res_hit_o, res_fault_o, miss_req_o}, 4'b1010);
          chk("R4 pa zero", res_pa_o, 12'h000);
        end
      endcase
    end

    // R5 idle cycle after a lookup
    look(14'h03D4, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R5 idle", {res_valid_o, res_hit_o, res_fault_o, miss_req_o, res_pa_o, miss_vpn_o}, '0);

    // R6 round-robin in set 2: tags 10..13 fill ways 0..3
    for (int t = 16; t < 20; t++) fill({6'(t), 2'd2}, 6'(t + 32), 1'b1, 1'b0, 1'b0);
    fill({6'd20, 2'd2}, 6'd52, 1'b1, 1'b0, 1'b0);
    exp_miss("R6 rr evict way0", {6'd16, 2'd2, 6'h00});
    exp_hit("R6 rr new", {6'd20, 2'd2, 6'h00}, {6'd52, 6'h00});
    exp_hit("R6 rr keep", {6'd17, 2'd2, 6'h00}, {6'd49, 6'h00});
    fill({6'd21, 2'd2}, 6'd53, 1'b1, 1'b0, 1'b0);
    exp_miss("R6 rr evict way1", {6'd17, 2'd2, 6'h00});
    exp_hit("R6 rr keep2", {6'd18, 2'd2, 6'h00}, {6'd50, 6'h00});
    exp_hit("R6 rr keep3", {6'd20, 2'd2, 6'h00}, {6'd52, 6'h00});

    // R6 same tag rewrites in place
    fill(8'h0F, 6'h1A, 1'b1, 1'b0, 1'b0);
    exp_hit("R6 rewrite", 14'h03D4, 12'h694);
    exp_hit("R6 rewrite other", 14'h0AC5, 12'hD05);

    // R7 lookup alongside refill sees old contents
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 8'h81; fill_ppn_i = 6'h27;
    fill_wr_i = 1'b1; fill_sup_i = 1'b0; fill_glb_i = 1'b0;
    lkp_valid_i = 1'b1; lkp_va_i = 14'h2040; lkp_write_i = 1'b0; lkp_user_i = 1'b0;
    @(negedge clk_i);
    fill_valid_i = 1'b0; lkp_valid_i = 1'b0;
    chk("R7 same cycle miss", {res_valid_o, res_hit_o, miss_req_o}, 3'b101);
    exp_hit("R7 next lookup", 14'h2040, 12'h9C0);

    // R8 flush keeps global, drops others; concurrent refill survives
    fill(8'h05, 6'h11, 1'b1, 1'b0, 1'b1);
    @(negedge clk_i);
    flush_i = 1'b1;
    fill_valid_i = 1'b1; fill_vpn_i = 8'h06; fill_ppn_i = 6'h22;
    fill_wr_i = 1'b1; fill_sup_i = 1'b0; fill_glb_i = 1'b0;
    @(negedge clk_i);
    flush_i = 1'b0; fill_valid_i = 1'b0;
    exp_hit("R8 global kept", 14'h0140, 12'h440);
    exp_miss("R8 local dropped", 14'h0361);
    exp_miss("R8 local dropped set0", 14'h093F);
    exp_miss("R8 local dropped set2", {6'd20, 2'd2, 6'h00});
    exp_hit("R8 fill with flush", 14'h0180, 12'h880);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule